// File: doc/BRIEF.md
# Silent Store Filter

This unit sits beside the store queue of an out-of-order core and removes cache writes that would not change memory. When a store executes, the unit records its tag, address, data and byte mask, and one cycle later it sends a read request for the same address to the data cache. When the cache answers, the returned word is compared with the store data on the enabled bytes only. A hit with equal enabled bytes marks the store silent. A miss, or any mismatch on an enabled byte, leaves it non-silent.

Between the answer and retirement, an invalidate input models a snoop or an older store to the same place. An invalidate that names the same aligned word as a tracked store clears that store's silent mark. At commit, a silent store retires with a one-cycle retire-silent pulse and no cache write. A non-silent store drives a one-cycle cache write carrying its own address, data and mask. Two counters give the number of suppressed stores and the number of written stores.

Top module: `ssd_top`

## Requirements
- R1: After reset, rd_valid, wr_valid and ret_silent are 0, and both counters read 0.
- R2: An executing store (exe_valid) causes rd_valid to be 1 on the next cycle, with rd_tag and rd_addr equal to that store's tag and address. rd_valid is 0 in every other cycle.
- R3: A store becomes silent only when its first read answer has rsp_hit=1 and rsp_data equals the store data on every byte whose mask bit is set. Byte i is data bits [8i+7:8i] and is enabled by mask bit i.
- R4: Bytes whose mask bit is 0 take no part in the comparison. A store with an all-zero mask that hits is silent.
- R5: A read answer with rsp_hit=0 leaves the store non-silent, whatever rsp_data holds.
- R6: An invalidate clears the silent mark of every tracked store whose address matches inv_addr on bits [31:3]. Stores whose addresses differ on those bits keep their mark.
- R7: Committing a silent store gives ret_silent=1 and wr_valid=0 on the next cycle, and cnt_suppressed goes up by 1.
- R8: Committing a non-silent store gives wr_valid=1 on the next cycle, with that store's address, data and mask, and cnt_written goes up by 1. Without a commit, neither output pulses.
- R9: An invalidate that matches a store in the same cycle as that store's read answer takes priority, and the store stays non-silent.
- R10: Only the first read answer for an executed store counts. A later answer for the same tag before it is executed again has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exe_valid | input | 1 | Store executes this cycle |
| exe_tag | input | 3 | Store queue slot of the executing store |
| exe_addr | input | 32 | Store byte address |
| exe_data | input | 64 | Store data |
| exe_mask | input | 8 | Store byte enables |
| rd_valid | output | 1 | Check-read request to the cache |
| rd_tag | output | 3 | Slot of the requesting store |
| rd_addr | output | 32 | Address to read |
| rsp_valid | input | 1 | Read answer present |
| rsp_tag | input | 3 | Slot the answer belongs to |
| rsp_hit | input | 1 | Answer hit in the cache |
| rsp_data | input | 64 | Word read from the cache |
| inv_valid | input | 1 | Snoop or older-store invalidate |
| inv_addr | input | 32 | Invalidate address |
| cmt_valid | input | 1 | A store retires this cycle |
| cmt_tag | input | 3 | Slot of the retiring store |
| wr_valid | output | 1 | Cache write of a non-silent store |
| wr_addr | output | 32 | Write address |
| wr_data | output | 64 | Write data |
| wr_mask | output | 8 | Write byte enables |
| ret_silent | output | 1 | Store retired without a write |
| cnt_suppressed | output | 16 | Count of suppressed stores |
| cnt_written | output | 16 | Count of written stores |

## Verification
The bench targets several corner cases. The first is a difference that sits only in disabled bytes: a design that compares the whole word would write a store that should be suppressed. The second is a miss that carries matching data: a design that ignores the hit bit would drop a store whose value it never saw. The third is an invalidate to the same word at another byte offset, or in the very cycle of the answer: a design that compares full addresses, or lets the answer win, would suppress a write that memory now needs. The last is a second answer to an already answered slot: a design that accepts it would flip the outcome of a store that had already been decided.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  parameter int unsigned SSD_ADDR_W = 32;
  parameter int unsigned SSD_DATA_W = 64;
  localparam int unsigned SSD_MASK_W = SSD_DATA_W / 8;
  localparam int unsigned SSD_OFS_W  = $clog2(SSD_MASK_W);

  typedef logic [SSD_ADDR_W-1:0] addr_t;
  typedef logic [SSD_DATA_W-1:0] data_t;
  typedef logic [SSD_MASK_W-1:0] mask_t;

  typedef struct packed {
    logic  valid;
    logic  answered;
    logic  silent;
    addr_t addr;
    data_t data;
    mask_t mask;
  } entry_t;

  // True when two byte addresses name the same aligned word.
  function automatic logic same_word(addr_t a, addr_t b);
    return a[SSD_ADDR_W-1:SSD_OFS_W] == b[SSD_ADDR_W-1:SSD_OFS_W];
  endfunction

  // Spread a byte mask into a bit mask.
  function automatic data_t bits_of_mask(mask_t m);
    data_t r;
    for (int i = 0; i < int'(SSD_MASK_W); i++) r[i*8 +: 8] = {8{m[i]}};
    return r;
  endfunction
endpackage

// File: rtl/ssd_masked_cmp.sv
module ssd_masked_cmp
  import ssd_pkg::*;
(
  input  logic   rsp_valid,
  input  logic   rsp_hit,
  input  data_t  rsp_data,
  input  entry_t ent,
  output logic   rsp_accept,
  output logic   rsp_match
);
  logic [SSD_MASK_W-1:0] byte_ok;

  for (genvar b = 0; b < int'(SSD_MASK_W); b++) begin : g_byte
    assign byte_ok[b] = !ent.mask[b] || (rsp_data[b*8 +: 8] == ent.data[b*8 +: 8]);
  end

  assign rsp_accept = rsp_valid && ent.valid && !ent.answered;
  assign rsp_match  = rsp_accept && rsp_hit && (&byte_ok);
endmodule

// File: rtl/ssd_entry_table.sv
module ssd_entry_table
  import ssd_pkg::*;
#(
  parameter int unsigned TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exe_valid,
  input  logic [TAG_W-1:0] exe_tag,
  input  addr_t            exe_addr,
  input  data_t            exe_data,
  input  mask_t            exe_mask,
  input  logic [TAG_W-1:0] rsp_tag,
  input  logic             rsp_accept,
  input  logic             rsp_match,
  input  logic             inv_valid,
  input  addr_t            inv_addr,
  input  logic             cmt_valid,
  input  logic [TAG_W-1:0] cmt_tag,
  output entry_t           rsp_ent,
  output entry_t           cmt_ent,
  output logic             inv_clear_any
);
  localparam int unsigned ENTRIES = 1 << TAG_W;

  entry_t               ent_all [ENTRIES];
  logic [ENTRIES-1:0]   inv_clear;

  for (genvar i = 0; i < int'(ENTRIES); i++) begin : g_ent
    entry_t e_q;
    logic   load_i, rsp_i, inv_i, cmt_i;

    assign load_i = exe_valid && (exe_tag == TAG_W'(i));
    assign rsp_i  = rsp_accept && (rsp_tag == TAG_W'(i)) && !load_i;
    assign inv_i  = inv_valid && e_q.valid && same_word(e_q.addr, inv_addr);
    assign cmt_i  = cmt_valid && (cmt_tag == TAG_W'(i));
    assign inv_clear[i] = inv_i && !load_i;
    assign ent_all[i]   = e_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_q.valid    <= 1'b0;
        e_q.answered <= 1'b0;
        e_q.silent   <= 1'b0;
        e_q.addr     <= '0;
        e_q.data     <= '0;
        e_q.mask     <= '0;
      end else if (load_i) begin
        e_q.valid    <= 1'b1;
        e_q.answered <= 1'b0;
        e_q.silent   <= 1'b0;
        e_q.addr     <= exe_addr;
        e_q.data     <= exe_data;
        e_q.mask     <= exe_mask;
      end else begin
        if (cmt_i) e_q.valid <= 1'b0;
        if (rsp_i) begin
          e_q.answered <= 1'b1;
          e_q.silent   <= rsp_match && !inv_i;
        end else if (inv_i) begin
          e_q.silent   <= 1'b0;
        end
      end
    end
  end

  assign rsp_ent       = ent_all[rsp_tag];
  assign cmt_ent       = ent_all[cmt_tag];
  assign inv_clear_any = |inv_clear;
endmodule

// File: rtl/ssd_retire.sv
module ssd_retire
  import ssd_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmt_valid,
  input  entry_t           cmt_ent,
  output logic             wr_valid,
  output addr_t            wr_addr,
  output data_t            wr_data,
  output mask_t            wr_mask,
  output logic             ret_silent,
  output logic [CNT_W-1:0] cnt_suppressed,
  output logic [CNT_W-1:0] cnt_written
);
  logic drop_now, write_now;

  assign drop_now  = cmt_valid && cmt_ent.silent;
  assign write_now = cmt_valid && !cmt_ent.silent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid       <= 1'b0;
      wr_addr        <= '0;
      wr_data        <= '0;
      wr_mask        <= '0;
      ret_silent     <= 1'b0;
      cnt_suppressed <= '0;
      cnt_written    <= '0;
    end else begin
      wr_valid   <= write_now;
      ret_silent <= drop_now;
      if (write_now) begin
        wr_addr     <= cmt_ent.addr;
        wr_data     <= cmt_ent.data;
        wr_mask     <= cmt_ent.mask;
        cnt_written <= cnt_written + CNT_W'(1);
      end
      if (drop_now) cnt_suppressed <= cnt_suppressed + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ssd_top.sv
module ssd_top
  import ssd_pkg::*;
#(
  parameter int unsigned TAG_W = 3,
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  exe_valid,
  input  logic [TAG_W-1:0]      exe_tag,
  input  logic [SSD_ADDR_W-1:0] exe_addr,
  input  logic [SSD_DATA_W-1:0] exe_data,
  input  logic [SSD_MASK_W-1:0] exe_mask,
  output logic                  rd_valid,
  output logic [TAG_W-1:0]      rd_tag,
  output logic [SSD_ADDR_W-1:0] rd_addr,
  input  logic                  rsp_valid,
  input  logic [TAG_W-1:0]      rsp_tag,
  input  logic                  rsp_hit,
  input  logic [SSD_DATA_W-1:0] rsp_data,
  input  logic                  inv_valid,
  input  logic [SSD_ADDR_W-1:0] inv_addr,
  input  logic                  cmt_valid,
  input  logic [TAG_W-1:0]      cmt_tag,
  output logic                  wr_valid,
  output logic [SSD_ADDR_W-1:0] wr_addr,
  output logic [SSD_DATA_W-1:0] wr_data,
  output logic [SSD_MASK_W-1:0] wr_mask,
  output logic                  ret_silent,
  output logic [CNT_W-1:0]      cnt_suppressed,
  output logic [CNT_W-1:0]      cnt_written
);
  entry_t rsp_ent, cmt_ent;
  logic   rsp_accept, rsp_match, inv_clear_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_tag   <= '0;
      rd_addr  <= '0;
    end else begin
      rd_valid <= exe_valid;
      if (exe_valid) begin
        rd_tag  <= exe_tag;
        rd_addr <= exe_addr;
      end
    end
  end

  ssd_masked_cmp u_cmp (
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_data  (rsp_data),
    .ent       (rsp_ent),
    .rsp_accept(rsp_accept),
    .rsp_match (rsp_match)
  );

  ssd_entry_table #(.TAG_W(TAG_W)) u_tab (
    .clk          (clk),
    .rst_n        (rst_n),
    .exe_valid    (exe_valid),
    .exe_tag      (exe_tag),
    .exe_addr     (exe_addr),
    .exe_data     (exe_data),
    .exe_mask     (exe_mask),
    .rsp_tag      (rsp_tag),
    .rsp_accept   (rsp_accept),
    .rsp_match    (rsp_match),
    .inv_valid    (inv_valid),
    .inv_addr     (inv_addr),
    .cmt_valid    (cmt_valid),
    .cmt_tag      (cmt_tag),
    .rsp_ent      (rsp_ent),
    .cmt_ent      (cmt_ent),
    .inv_clear_any(inv_clear_any)
  );

  ssd_retire #(.CNT_W(CNT_W)) u_ret (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmt_valid     (cmt_valid),
    .cmt_ent       (cmt_ent),
    .wr_valid      (wr_valid),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .wr_mask       (wr_mask),
    .ret_silent    (ret_silent),
    .cnt_suppressed(cnt_suppressed),
    .cnt_written   (cnt_written)
  );
endmodule

// File: rtl/ssd_chk.sv
module ssd_chk #(
  parameter int unsigned TAG_W = 3,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exe_valid,
  input logic [TAG_W-1:0] exe_tag,
  input logic             rd_valid,
  input logic [TAG_W-1:0] rd_tag,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_match,
  input logic             cmt_valid,
  input logic             wr_valid,
  input logic             ret_silent,
  input logic [CNT_W-1:0] cnt_suppressed,
  input logic [CNT_W-1:0] cnt_written
);
  AST_RD_AFTER_EXE: assert property (@(posedge clk) disable iff (!rst_n) exe_valid |=> (rd_valid && rd_tag == $past(exe_tag))); // R2
  AST_RD_ONLY_EXE: assert property (@(posedge clk) disable iff (!rst_n) !exe_valid |=> !rd_valid); // R2
  AST_MISS_NOT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_hit) |-> !rsp_match); // R5
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) cmt_valid |=> (wr_valid != ret_silent)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !cmt_valid |=> (!wr_valid && !ret_silent)); // R8
  AST_SUP_COUNT: assert property (@(posedge clk) disable iff (!rst_n) ret_silent |-> cnt_suppressed == $past(cnt_suppressed) + CNT_W'(1)); // R7
  AST_WR_COUNT: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |-> cnt_written == $past(cnt_written) + CNT_W'(1)); // R8
endmodule

bind ssd_top ssd_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .exe_valid     (exe_valid),
  .exe_tag       (exe_tag),
  .rd_valid      (rd_valid),
  .rd_tag        (rd_tag),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_match     (rsp_match),
  .cmt_valid     (cmt_valid),
  .wr_valid      (wr_valid),
  .ret_silent    (ret_silent),
  .cnt_suppressed(cnt_suppressed),
  .cnt_written   (cnt_written)
);

// File: tb/sim_ssd_top.sv
module sim_ssd_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exe_valid = 1'b0;
  logic [2:0]  exe_tag = '0;
  logic [31:0] exe_addr = '0;
  logic [63:0] exe_data = '0;
  logic [7:0]  exe_mask = '0;
  logic        rd_valid;
  logic [2:0]  rd_tag;
  logic [31:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [2:0]  rsp_tag = '0;
  logic        rsp_hit = 1'b0;
  logic [63:0] rsp_data = '0;
  logic        inv_valid = 1'b0;
  logic [31:0] inv_addr = '0;
  logic        cmt_valid = 1'b0;
  logic [2:0]  cmt_tag = '0;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_mask;
  logic        ret_silent;
  logic [15:0] cnt_suppressed, cnt_written;

  int n_chk = 0, n_bad = 0;
  logic [15:0] e_sup = 0, e_wr = 0;

  // bench model of the tracked stores
  logic        m_valid [8];
  logic        m_ans   [8];
  logic        m_sil   [8];
  logic [31:0] m_addr  [8];
  logic [63:0] m_data  [8];
  logic [7:0]  m_mask  [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  ssd_top u0 (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic enabled_equal(logic [63:0] a, logic [63:0] b, logic [7:0] m);
    logic ok = 1'b1;
    for (int k = 0; k < 8; k++)
      if (m[k] && (a[k*8 +: 8] != b[k*8 +: 8])) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic word_match(logic [31:0] a, logic [31:0] b);
    return (a >> 3) == (b >> 3);
  endfunction

  task automatic do_exe(input logic [2:0] t, input logic [31:0] a, input logic [63:0] d, input logic [7:0] m);
    @(negedge clk);
    exe_valid = 1; exe_tag = t; exe_addr = a; exe_data = d; exe_mask = m;
    @(negedge clk);
    exe_valid = 0;
    chk(rd_valid && rd_tag == t && rd_addr == a, "R2 read request", {31'd0, rd_valid, rd_addr}, {31'd1, 1'b1, a});
    m_valid[t] = 1; m_ans[t] = 0; m_sil[t] = 0; m_addr[t] = a; m_data[t] = d; m_mask[t] = m;
  endtask

  task automatic model_inv(input logic [31:0] a);
    for (int k = 0; k < 8; k++)
      if (m_valid[k] && word_match(m_addr[k], a)) m_sil[k] = 0;
  endtask

  task automatic do_rsp(input logic [2:0] t, input logic h, input logic [63:0] d,
                        input logic iv, input logic [31:0] ia);
    @(negedge clk);
    rsp_valid = 1; rsp_tag = t; rsp_hit = h; rsp_data = d; inv_valid = iv; inv_addr = ia;
    @(negedge clk);
    rsp_valid = 0; inv_valid = 0;
    chk(!rd_valid, "R2 no stray read", {63'd0, rd_valid}, 64'd0);
    if (m_valid[t] && !m_ans[t]) begin
      m_ans[t] = 1;
      m_sil[t] = h && enabled_equal(d, m_data[t], m_mask[t]);
    end
    if (iv) model_inv(ia);
  endtask

  task automatic do_inv(input logic [31:0] a);
    @(negedge clk);
    inv_valid = 1; inv_addr = a;
    @(negedge clk);
    inv_valid = 0;
    model_inv(a);
  endtask

  task automatic do_cmt(input logic [2:0] t, input string req);
    logic s;
    s = m_sil[t];
    @(negedge clk);
    cmt_valid = 1; cmt_tag = t;
    @(negedge clk);
    cmt_valid = 0;
    m_valid[t] = 0;
    if (s) begin
      e_sup++;
      chk(ret_silent && !wr_valid, {req, " R7 suppressed"}, {62'd0, ret_silent, wr_valid}, 64'b10);
      chk(cnt_suppressed == e_sup, {req, " R7 count"}, 64'(cnt_suppressed), 64'(e_sup));
    end else begin
      e_wr++;
      chk(wr_valid && !ret_silent, {req, " R8 written"}, {62'd0, ret_silent, wr_valid}, 64'b01);
      chk(wr_addr == m_addr[t] && wr_mask == m_mask[t], {req, " R8 addr/mask"},
          {24'd0, wr_mask, wr_addr}, {24'd0, m_mask[t], m_addr[t]});
      chk(wr_data == m_data[t], {req, " R8 data"}, wr_data, m_data[t]);
      chk(cnt_written == e_wr, {req, " R8 count"}, 64'(cnt_written), 64'(e_wr));
    end
    @(negedge clk);
    chk(!wr_valid && !ret_silent, "R8 single pulse", {62'd0, ret_silent, wr_valid}, 64'd0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    logic [63:0] base;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) begin m_valid[k] = 0; m_ans[k] = 0; m_sil[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!rd_valid && !wr_valid && !ret_silent, "R1 outputs idle", {61'd0, rd_valid, wr_valid, ret_silent}, 64'd0);
    chk(cnt_suppressed == 0 && cnt_written == 0, "R1 counters", {32'd0, cnt_suppressed, cnt_written}, 64'd0);

    // R3: hit, all bytes equal -> silent
    base = 64'h0123_4567_89ab_cdef;
    do_exe(3'd1, 32'h0000_1000, base, 8'hff);
    do_rsp(3'd1, 1'b1, base, 1'b0, '0);
    do_cmt(3'd1, "R3 equal hit");
    // R3: one enabled byte differs -> written
    do_exe(3'd2, 32'h0000_2008, base, 8'hff);
    do_rsp(3'd2, 1'b1, base ^ 64'h0000_0100_0000_0000, 1'b0, '0);
    do_cmt(3'd2, "R3 differ");
    // R4: difference only in disabled bytes -> silent
    do_exe(3'd3, 32'h0000_3000, base, 8'h0f);
    do_rsp(3'd3, 1'b1, base ^ 64'hffff_ffff_0000_0000, 1'b0, '0);
    do_cmt(3'd3, "R4 masked bytes");
    // R4: empty mask hit -> silent
    do_exe(3'd4, 32'h0000_3010, base, 8'h00);
    do_rsp(3'd4, 1'b1, ~base, 1'b0, '0);
    do_cmt(3'd4, "R4 empty mask");
    // R5: miss with equal data -> written
    do_exe(3'd5, 32'h0000_4000, base, 8'hff);
    do_rsp(3'd5, 1'b0, base, 1'b0, '0);
    do_cmt(3'd5, "R5 miss");
    // R6: invalidate same word, other byte offset -> written
    do_exe(3'd6, 32'h0000_5000, base, 8'hff);
    do_rsp(3'd6, 1'b1, base, 1'b0, '0);
    do_inv(32'h0000_5005);
    do_cmt(3'd6, "R6 inv match");
    // R6: invalidate of neighbouring word -> still silent
    do_exe(3'd7, 32'h0000_5000, base, 8'hff);
    do_rsp(3'd7, 1'b1, base, 1'b0, '0);
    do_inv(32'h0000_5008);
    do_cmt(3'd7, "R6 inv other");
    // R9: invalidate in the answer cycle wins
    do_exe(3'd0, 32'h0000_6000, base, 8'hff);
    do_rsp(3'd0, 1'b1, base, 1'b1, 32'h0000_6002);
    do_cmt(3'd0, "R9 inv with answer");
    // R10: miss then a late equal hit -> still written
    do_exe(3'd1, 32'h0000_7000, base, 8'hff);
    do_rsp(3'd1, 1'b0, 64'd0, 1'b0, '0);
    do_rsp(3'd1, 1'b1, base, 1'b0, '0);
    do_cmt(3'd1, "R10 late answer");
    // R10: equal hit then a late differing answer -> still silent
    do_exe(3'd2, 32'h0000_7100, base, 8'hff);
    do_rsp(3'd2, 1'b1, base, 1'b0, '0);
    do_rsp(3'd2, 1'b1, ~base, 1'b0, '0);
    do_cmt(3'd2, "R10 second answer");

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      logic [2:0]  t;
      logic [31:0] a;
      logic [63:0] d, r;
      logic [7:0]  m;
      int sel;
      t = 3'($urandom % 8);
      a = {16'h0000, 13'($urandom), 3'($urandom)};
      d = {$urandom, $urandom};
      m = 8'($urandom);
      do_exe(t, a, d, m);
      sel = $urandom % 10;
      r = (sel < 6) ? ((d & {{8{m[7]}}, {8{m[6]}}, {8{m[5]}}, {8{m[4]}}, {8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}})
                       | ({$urandom, $urandom} & ~{{8{m[7]}}, {8{m[6]}}, {8{m[5]}}, {8{m[4]}}, {8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}}))
                    : {$urandom, $urandom};
      do_rsp(t, ($urandom % 4) != 0, r, ($urandom % 5) == 0,
             (($urandom % 2) == 0) ? (a ^ 32'($urandom % 8)) : (a ^ 32'h8));
      if (($urandom % 4) == 0)
        do_inv((($urandom % 2) == 0) ? {a[31:3], 3'($urandom)} : (a + 32'h10));
      do_cmt(t, "R3 R4 R5 R6 random");
    end
    finish_run();
  end
endmodule